// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small synchronizing memory for processor-side producer/consumer hand-off. Each 32-bit data word carries one extra presence bit, so every stored entry is 33 bits wide. The presence bit is either full (1) or empty (0). Words are grouped four to a line, and the four presence bits of a line are stored together and reported together.

A processor issues at most one command per cycle. Plain loads and stores move data and leave the presence bit alone. The synchronizing variants test the bit and update it in the same access. A load can fail when the word is empty, and it can also drain the word. A store can refill the word unconditionally, or fail when the word is already full. A command that fails leaves the memory untouched. Instead of completing, it raises a one-cycle trap flag together with the faulting address, which a software handler can then act on. All presence bits come out of reset empty. Every command gets a registered response one cycle after it is issued.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset every presence bit is empty (0), and `rsp_valid` and `trap` are low.
- R2: A command accepted on a clock edge (`req_valid` high) produces `rsp_valid` high for exactly the following cycle. With no command there is no response.
- R3: A plain load (op 0) returns the stored word. A plain store (op 1) writes the word. Neither one changes the presence bit, and neither one traps.
- R4: A filling store (op 4) writes the word and sets its presence bit to full, whatever the bit held before. It never traps.
- R5: A checked load (op 2) traps when the word is empty. When the word is full it returns the data and the bit stays full.
- R6: A draining load (op 3) traps when the word is empty. When the word is full it returns the data and clears the bit to empty in the same access.
- R7: A guarded store (op 5) traps when the word is already full. When the word is empty it writes the data and sets the bit to full.
- R8: A trapped command changes neither the data nor the presence bit. `trap` is high for one cycle, together with `rsp_valid`. `trap_addr` carries the command's address and `rsp_data` is 0.
- R9: `rsp_tag` gives the addressed word's presence bit as it was before the access. `rsp_line_tags` gives the four presence bits of the addressed line before the access, with bit i belonging to the word whose address has low bits equal to i.
- R10: Op codes 6 and 7 are reserved. They change nothing, return `rsp_data` 0 and never trap.
- R11: A command issued in the cycle right after another one sees that command's data and presence-bit update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 3 | Command code (0..5 defined, 6..7 reserved) |
| req_addr | input | ADDR_W | Word address; the low 2 bits select the word within its line |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_data | output | DATA_W | Load data, or 0 |
| rsp_tag | output | 1 | Presence bit of the addressed word before the access |
| rsp_line_tags | output | WORDS_PER_LINE | Presence bits of the addressed line before the access |
| trap | output | 1 | The command failed on its presence bit |
| trap_addr | output | ADDR_W | Address of the failed command, 0 otherwise |

## Verification
A presence bit that holds the wrong value becomes visible on the very next command that touches its line. The bad value appears on `rsp_tag` and `rsp_line_tags` one cycle after that command is issued. A lost or spurious update also flips the trap decision of the next synchronizing command on that word. Data that is written when it should not be, or not written when it should be, shows up as a wrong `rsp_data` on the next load of that word. The bench therefore follows every update with a load on the same word, usually in the very next cycle.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

    typedef enum logic [2:0] {
        OP_LOAD       = 3'd0,
        OP_STORE      = 3'd1,
        OP_LOAD_CHK   = 3'd2,
        OP_LOAD_TAKE  = 3'd3,
        OP_STORE_FILL = 3'd4,
        OP_STORE_PUT  = 3'd5,
        OP_RSV6       = 3'd6,
        OP_RSV7       = 3'd7
    } fe_op_e;

    // Control bits derived from one command code
    typedef struct packed {
        logic rd_data;    // command returns word data
        logic want_full;  // trap when the word is empty
        logic want_empty; // trap when the word is full
        logic wr_data;    // command writes word data
        logic tag_we;     // command updates the presence bit
        logic tag_val;    // value written to the presence bit
    } fe_ctl_t;

endpackage

// File: rtl/fe_decode.sv
module fe_decode
    import fe_mem_pkg::*;
(
    input  fe_op_e  op,
    output fe_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (op)
            OP_LOAD:       ctl.rd_data = 1'b1;
            OP_STORE:      ctl.wr_data = 1'b1;
            OP_LOAD_CHK: begin
                ctl.rd_data   = 1'b1;
                ctl.want_full = 1'b1;
            end
            OP_LOAD_TAKE: begin
                ctl.rd_data   = 1'b1;
                ctl.want_full = 1'b1;
                ctl.tag_we    = 1'b1;
                ctl.tag_val   = 1'b0;
            end
            OP_STORE_FILL: begin
                ctl.wr_data = 1'b1;
                ctl.tag_we  = 1'b1;
                ctl.tag_val = 1'b1;
            end
            OP_STORE_PUT: begin
                ctl.wr_data    = 1'b1;
                ctl.want_empty = 1'b1;
                ctl.tag_we     = 1'b1;
                ctl.tag_val    = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/fe_word_array.sv
module fe_word_array #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
    parameter int LINES = 16,
    parameter int WPL   = 4,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int WSEL_W = (WPL > 1) ? $clog2(WPL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [WSEL_W-1:0] word,
    input  logic              we,
    input  logic              wval,
    output logic [WPL-1:0]    line_tags
);
    logic [WPL-1:0] tags_q [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [WPL-1:0] tags_d;
        always_comb begin
            tags_d = tags_q[l];
            if (we && (line == LINE_W'(l))) tags_d[word] = wval;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) tags_q[l] <= '0;
            else        tags_q[l] <= tags_d;
        end
    end

    assign line_tags = tags_q[line];
endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem
    import fe_mem_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int ADDR_W         = 6,
    parameter int WORDS_PER_LINE = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [2:0]                req_op,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      rsp_tag,
    output logic [WORDS_PER_LINE-1:0] rsp_line_tags,
    output logic                      trap,
    output logic [ADDR_W-1:0]         trap_addr
);
    localparam int WSEL_W = $clog2(WORDS_PER_LINE);
    localparam int LINE_W = ADDR_W - WSEL_W;
    localparam int LINES  = 1 << LINE_W;

    typedef struct packed {
        logic                      valid;
        logic [DATA_W-1:0]         data;
        logic                      tag;
        logic [WORDS_PER_LINE-1:0] line_tags;
        logic                      trap;
        logic [ADDR_W-1:0]         trap_addr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    fe_ctl_t             ctl;
    logic [LINE_W-1:0]   line_idx;
    logic [WSEL_W-1:0]   word_idx;
    logic [WORDS_PER_LINE-1:0] cur_tags;
    logic                cur_tag;
    logic [DATA_W-1:0]   cur_data;
    logic                fault;
    logic                commit;

    assign line_idx = req_addr[ADDR_W-1:WSEL_W];
    assign word_idx = req_addr[WSEL_W-1:0];

    fe_decode u_dec (
        .op  (fe_op_e'(req_op)),
        .ctl (ctl)
    );

    fe_word_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_words (
        .clk   (clk),
        .we    (commit && ctl.wr_data),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (cur_data)
    );

    fe_tag_array #(.LINES(LINES), .WPL(WORDS_PER_LINE)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (line_idx),
        .word      (word_idx),
        .we        (commit && ctl.tag_we),
        .wval      (ctl.tag_val),
        .line_tags (cur_tags)
    );

    assign cur_tag = cur_tags[word_idx];
    assign fault   = req_valid && ((ctl.want_full && !cur_tag) || (ctl.want_empty && cur_tag));
    assign commit  = req_valid && !fault;

    always_comb begin
        rsp_d           = '0;
        rsp_d.valid     = req_valid;
        if (req_valid) begin
            rsp_d.tag       = cur_tag;
            rsp_d.line_tags = cur_tags;
            rsp_d.trap      = fault;
            rsp_d.trap_addr = fault ? req_addr : '0;
            rsp_d.data      = (ctl.rd_data && !fault) ? cur_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_data      = rsp_q.data;
    assign rsp_tag       = rsp_q.tag;
    assign rsp_line_tags = rsp_q.line_tags;
    assign trap          = rsp_q.trap;
    assign trap_addr     = rsp_q.trap_addr;
endmodule

// File: rtl/fe_mem_chk.sv
module fe_mem_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_tag,
    input logic              trap,
    input logic [ADDR_W-1:0] trap_addr
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_TRAP_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (rsp_valid && rsp_data == '0)); // R8
    AST_TRAP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> trap_addr == $past(req_addr)); // R8
    AST_FILL_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> !trap); // R4
    AST_PLAIN_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op <= 3'd1) |=> !trap); // R3
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op >= 3'd6) |=> (!trap && rsp_data == '0)); // R10
    AST_TAKE_SAW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) |=> (trap != rsp_tag)); // R6
    AST_PUT_SAW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |=> (trap == rsp_tag)); // R7
endmodule

bind fe_tagged_mem fe_mem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_tag   (rsp_tag),
    .trap      (trap),
    .trap_addr (trap_addr)
);

// File: tb/tb_fe_tagged_mem.sv
`timescale 1ns/1ps
module tb_fe_tagged_mem;
    localparam int DW = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_tag;
    logic [3:0]    rsp_line_tags;
    logic          trap;
    logic [AW-1:0] trap_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fe_tagged_mem #(.DATA_W(DW), .ADDR_W(AW), .WORDS_PER_LINE(4)) dut (
        .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata,
        .rsp_valid, .rsp_data, .rsp_tag, .rsp_line_tags, .trap, .trap_addr
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one command at a falling edge; return at the next falling edge with the response visible
    task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "trap", 32'(trap), 0);
        @(negedge clk);
        chk("R2", "idle rsp_valid", 32'(rsp_valid), 0);
        cmd(3'd2, 6'd5, 0);
        chk("R1", "empty after reset traps", 32'(trap), 1);
        chk("R1", "line tags", 32'(rsp_line_tags), 0);
        chk("R2", "rsp_valid", 32'(rsp_valid), 1);
        @(negedge clk);
        chk("R8", "trap one cycle", 32'(trap), 0);
        chk("R2", "rsp_valid drops", 32'(rsp_valid), 0);
    endtask

    task automatic t_plain();
        cmd(3'd1, 6'd3, 32'hA5A5_0003);
        chk("R3", "store no trap", 32'(trap), 0);
        cmd(3'd0, 6'd3, 0);
        chk("R3", "load data", rsp_data, 32'hA5A5_0003);
        chk("R3", "tag stays empty", 32'(rsp_tag), 0);
        cmd(3'd4, 6'd9, 32'h1111_0009);
        cmd(3'd1, 6'd9, 32'h2222_0009);
        chk("R3", "plain store sees full", 32'(rsp_tag), 1);
        cmd(3'd0, 6'd9, 0);
        chk("R3", "plain store data", rsp_data, 32'h2222_0009);
        chk("R3", "tag preserved", 32'(rsp_tag), 1);
    endtask

    task automatic t_fill_chk();
        cmd(3'd4, 6'd10, 32'hC0DE_0010);
        chk("R4", "fill on empty no trap", 32'(trap), 0);
        cmd(3'd4, 6'd10, 32'hC0DE_1010);
        chk("R4", "fill on full no trap", 32'(trap), 0);
        chk("R4", "second fill saw full", 32'(rsp_tag), 1);
        cmd(3'd2, 6'd10, 0);
        chk("R5", "checked load data", rsp_data, 32'hC0DE_1010);
        chk("R5", "checked load no trap", 32'(trap), 0);
        cmd(3'd0, 6'd10, 0);
        chk("R5", "tag stays full", 32'(rsp_tag), 1);
    endtask

    task automatic t_take();
        cmd(3'd3, 6'd10, 0);
        chk("R6", "take data", rsp_data, 32'hC0DE_1010);
        chk("R6", "take no trap", 32'(trap), 0);
        cmd(3'd3, 6'd10, 0);
        chk("R6", "take on empty traps", 32'(trap), 1);
        chk("R8", "trap data zero", rsp_data, 0);
        chk("R8", "trap_addr", 32'(trap_addr), 10);
        cmd(3'd0, 6'd10, 0);
        chk("R8", "data kept after trap", rsp_data, 32'hC0DE_1010);
        chk("R6", "tag empty after take", 32'(rsp_tag), 0);
    endtask

    task automatic t_put();
        cmd(3'd5, 6'd20, 32'h0000_BEEF);
        chk("R7", "put on empty no trap", 32'(trap), 0);
        cmd(3'd5, 6'd20, 32'h0000_DEAD);
        chk("R7", "put on full traps", 32'(trap), 1);
        chk("R8", "trap_addr", 32'(trap_addr), 20);
        cmd(3'd0, 6'd20, 0);
        chk("R8", "no write on trap", rsp_data, 32'h0000_BEEF);
        chk("R7", "tag full", 32'(rsp_tag), 1);
    endtask

    task automatic t_line();
        cmd(3'd4, 6'd4, 32'h4);
        cmd(3'd4, 6'd6, 32'h6);
        cmd(3'd0, 6'd5, 0);
        chk("R9", "line tags", 32'(rsp_line_tags), 32'b0101);
        chk("R9", "word tag", 32'(rsp_tag), 0);
        cmd(3'd3, 6'd6, 0);
        chk("R9", "tags before take", 32'(rsp_line_tags), 32'b0101);
        cmd(3'd0, 6'd7, 0);
        chk("R9", "tags after take", 32'(rsp_line_tags), 32'b0001);
    endtask

    task automatic t_reserved();
        cmd(3'd6, 6'd20, 32'hFFFF_FFFF);
        chk("R10", "op6 data", rsp_data, 0);
        chk("R10", "op6 trap", 32'(trap), 0);
        cmd(3'd7, 6'd20, 32'hFFFF_FFFF);
        chk("R10", "op7 trap", 32'(trap), 0);
        cmd(3'd0, 6'd20, 0);
        chk("R10", "data unchanged", rsp_data, 32'h0000_BEEF);
        chk("R10", "tag unchanged", 32'(rsp_tag), 1);
    endtask

    task automatic t_b2b();
        cmd(3'd4, 6'd30, 32'h3030_3030);
        cmd(3'd3, 6'd30, 0);
        chk("R11", "take sees fill", rsp_data, 32'h3030_3030);
        cmd(3'd2, 6'd30, 0);
        chk("R11", "checked load sees take", 32'(trap), 1);
        cmd(3'd5, 6'd30, 32'h5);
        chk("R11", "put after trap ok", 32'(trap), 0);
        cmd(3'd2, 6'd30, 0);
        chk("R11", "checked load sees put", rsp_data, 32'h5);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_fill_chk();
        t_take();
        t_put();
        t_line();
        t_reserved();
        t_b2b();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule